// File: doc/BRIEF.md
# Quarter-Wave Sine and Cosine Lookup

The block turns an unsigned phase word into a signed sine sample and a signed cosine sample. It stores one quarter of a period as a magnitude table. The table is filled by a constant function when the design is elaborated, so no external file is needed. The other three quarters come from two operations. The address is mirrored by complementing the low phase bits, and the sign of the output is inverted.

Each phase code samples the waveform at the centre of its step, half a code above the code itself. This makes the four quarters exactly symmetric, so mirroring and negating the stored values introduces no rounding error of its own. The cosine is the sine of the same phase advanced by one quarter turn. It reads the same table through a second port.

A parameter sets the number of output register stages, and zero gives a purely combinational path. The registers move only while the clock enable is high, and a synchronous reset clears them.

Top module: `sincos_lut`

## Requirements
- R1: With P phase bits, M amplitude bits and A = 2^(M-1)-1, phase code k gives a sine output equal to the nearest integer to A·sin(2π·(k+0.5)/2^P). The error is therefore below half an output LSB.
- R2: For the same phase code k, the cosine output equals the nearest integer to A·cos(2π·(k+0.5)/2^P).
- R3: Neither output ever takes the most negative code -2^(M-1), and the magnitude of each output never exceeds A.
- R4: Codes half a period apart give opposite sine values: sine(k + 2^(P-1)) = -sine(k).
- R5: Within the first half period, codes at equal distance from the peak give equal sine values: sine(k) = sine(2^(P-1)-1-k).
- R6: A new phase reaches both outputs after exactly STAGES clock edges with the enable high. With STAGES = 0 it appears in the same cycle.
- R7: While the clock enable is low, both outputs hold their value whatever the phase input does.
- R8: When STAGES > 0, a clock edge with reset high clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| ce | input | 1 | Clock enable for the output registers |
| rst | input | 1 | Synchronous reset, active high |
| phase_i | input | PHASE_W | Unsigned phase code |
| sin_o | output | AMP_W | Signed sine sample |
| cos_o | output | AMP_W | Signed cosine sample |

## Verification
The assertions assume the following about the inputs:
- The clock enable and reset are known at every rising edge.
- Reset is held for at least one edge before any check counts.
- The parameters give a phase word of at least three bits.

Under those conditions, the sign of every unregistered sample must follow the folded quadrant. The outputs must also keep clear of the most negative code.

The stimulus raises reset from time zero and changes inputs only on falling edges. It sweeps every phase code once with the enable high, then drives the phase while the enable is low. Finally it resets in mid-run, which leaves every assumption intact.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam real SC_PI = 3.14159265358979323846;

    // Odd power series for sine, accurate far beyond one LSB on [0, pi/2].
    function automatic real sc_sine(input real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int n = 1; n < 14; n++) begin
            term = -term * x * x / real'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Scaled, rounded magnitude of quarter-table entry j (always positive).
    function automatic int sc_entry(input int j, input int depth, input int amp_w);
        real theta;
        real scale;
        theta = 2.0 * SC_PI * (real'(j) + 0.5) / real'(4 * depth);
        scale = real'((1 << (amp_w - 1)) - 1);
        return $rtoi(scale * sc_sine(theta) + 0.5);
    endfunction

endpackage

// File: rtl/sc_qrom.sv
module sc_qrom #(
    parameter int ADDR_W = 6,
    parameter int AMP_W  = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [AMP_W-1:0]  mag_o
);
    import sc_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    typedef logic [DEPTH-1:0][AMP_W-1:0] table_t;

    function automatic table_t fill_table();
        table_t t;
        for (int j = 0; j < DEPTH; j++) begin
            t[j] = AMP_W'(sc_entry(j, DEPTH, AMP_W));
        end
        return t;
    endfunction

    localparam table_t QTABLE = fill_table();

    assign mag_o = QTABLE[addr_i];

endmodule

// File: rtl/sc_pipe.sv
module sc_pipe #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 16
) (
    input  logic             clk,
    input  logic             ce,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_regs
            typedef struct packed {
                logic [STAGES-1:0][WIDTH-1:0] stage;
            } pipe_t;

            pipe_t pipe_d, pipe_q;

            always_comb begin
                pipe_d = pipe_q;
                if (rst) begin
                    pipe_d.stage = '0;
                end else if (ce) begin
                    pipe_d.stage[0] = din;
                    for (int i = 1; i < STAGES; i++) begin
                        pipe_d.stage[i] = pipe_q.stage[i-1];
                    end
                end
            end

            always_ff @(posedge clk) begin
                pipe_q <= pipe_d;
            end

            assign dout = pipe_q.stage[STAGES-1];

            // R7: a cycle with the enable low leaves the output unchanged
            a_r7_hold_when_idle: assert property (
                @(posedge clk) disable iff (rst) !ce |=> $stable(dout));

            // R8: reset clears the output on the next edge
            a_r8_reset_clears: assert property (
                @(posedge clk) rst |=> dout == '0);
        end
    endgenerate

endmodule

// File: rtl/sincos_lut.sv
module sincos_lut #(
    parameter int PHASE_W = 8,
    parameter int AMP_W   = 8,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               ce,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_i,
    output logic [AMP_W-1:0]   sin_o,
    output logic [AMP_W-1:0]   cos_o
);
    localparam int ADDR_W = PHASE_W - 2;
    localparam logic [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

    logic [1:0][AMP_W-1:0] amp;
    logic [2*AMP_W-1:0]    piped;

    // Channel 0 is sine; channel 1 is the same phase one quarter turn later.
    generate
        for (genvar ch = 0; ch < 2; ch++) begin : g_chan
            logic [1:0]        quad;
            logic [ADDR_W-1:0] low;
            logic [ADDR_W-1:0] addr;
            logic [AMP_W-1:0]  mag;
            logic              neg;

            assign quad = phase_i[PHASE_W-1 -: 2] + 2'(ch);
            assign low  = phase_i[ADDR_W-1:0];
            assign addr = quad[0] ? ~low : low;
            assign neg  = quad[1];

            sc_qrom #(
                .ADDR_W (ADDR_W),
                .AMP_W  (AMP_W)
            ) u_rom (
                .addr_i (addr),
                .mag_o  (mag)
            );

            assign amp[ch] = neg ? (~mag + 1'b1) : mag;

            // R4: a nonzero sample carries the sign of its folded half period
            a_r4_sign_follows_quadrant: assert property (
                @(posedge clk) disable iff (rst)
                (amp[ch] != '0) |-> (amp[ch][AMP_W-1] == quad[1]));
        end
    endgenerate

    sc_pipe #(
        .STAGES (STAGES),
        .WIDTH  (2 * AMP_W)
    ) u_pipe (
        .clk  (clk),
        .ce   (ce),
        .rst  (rst),
        .din  ({amp[0], amp[1]}),
        .dout (piped)
    );

    assign sin_o = piped[2*AMP_W-1:AMP_W];
    assign cos_o = piped[AMP_W-1:0];

    // R3: the most negative code is never produced
    a_r3_no_most_negative: assert property (
        @(posedge clk) disable iff (rst)
        (sin_o != MOST_NEG) && (cos_o != MOST_NEG));

endmodule

// File: tb/sim_sincos_lut.sv
module sim_sincos_lut;

    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;
    localparam int AW = 8;
    localparam int ST = 2;
    localparam int NCODES = 1 << PW;
    localparam int AMAX = (1 << (AW - 1)) - 1;
    localparam int MQ = (ST > 0) ? ST : 1;

    logic          clk = 1'b0;
    logic          ce = 1'b1;
    logic          rst = 1'b1;
    logic [PW-1:0] phase = '0;
    logic [AW-1:0] sin_o, cos_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int mq [MQ];
    int got_sin [NCODES];
    bit record_en = 0;
    string tag_s = "R8";
    string tag_c = "R8";

    sincos_lut #(.PHASE_W(PW), .AMP_W(AW), .STAGES(ST)) u0 (
        .clk(clk), .ce(ce), .rst(rst), .phase_i(phase),
        .sin_o(sin_o), .cos_o(cos_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int rnd(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    function automatic int ref_amp(input int k, input bit cosine);
        real th;
        th = 2.0 * 3.14159265358979323846 * (real'(k) + 0.5) / real'(NCODES);
        return rnd(real'(AMAX) * (cosine ? $cos(th) : $sin(th)));
    endfunction

    // Behavioural model: history of the phases that entered the output stages.
    initial for (int i = 0; i < MQ; i++) mq[i] = -1;
    always @(posedge clk) begin
        if (ST > 0) begin
            if (rst) begin
                for (int i = 0; i < MQ; i++) mq[i] = -1;
            end else if (ce) begin
                for (int i = MQ - 1; i > 0; i--) mq[i] = mq[i-1];
                mq[0] = int'(phase);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        int ph;
        int es, ec;
        @(negedge clk);
        ph = (ST == 0) ? int'(phase) : mq[MQ-1];
        es = (ph < 0) ? 0 : ref_amp(ph, 1'b0);
        ec = (ph < 0) ? 0 : ref_amp(ph, 1'b1);
        check(tag_s, int'($signed(sin_o)), es);
        check(tag_c, int'($signed(cos_o)), ec);
        if (record_en && ph >= 0) got_sin[ph] = int'($signed(sin_o));
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int held_s, held_c, cnt;
        // R8: outputs are zero while reset is applied
        repeat (3) step();
        rst = 1'b0;
        // R1 and R2: sweep every phase code once
        tag_s = "R1"; tag_c = "R2";
        record_en = 1;
        for (int k = 0; k < NCODES + ST + 1; k++) begin
            phase = PW'(k % NCODES);
            step();
        end
        record_en = 0;
        for (int k = 0; k < NCODES; k++) begin
            // R3: range and missing most negative code
            check("R3", int'(got_sin[k] >= -AMAX && got_sin[k] <= AMAX), 1);
            // R4: half-period opposite sign
            if (k < NCODES / 2) check("R4", got_sin[k + NCODES/2], -got_sin[k]);
            // R5: mirror about the peak
            if (k < NCODES / 2) check("R5", got_sin[k], got_sin[NCODES/2 - 1 - k]);
        end
        // R6: latency of exactly ST edges
        tag_s = "R6"; tag_c = "R6";
        phase = PW'(5);
        repeat (ST + 2) step();
        phase = PW'(200);
        cnt = 0;
        while (int'($signed(sin_o)) != ref_amp(200, 1'b0) && cnt < 10) begin
            step();
            cnt++;
        end
        check("R6", cnt, ST);
        // R7: enable low freezes the outputs
        if (ST > 0) begin
            tag_s = "R7"; tag_c = "R7";
            step();
            held_s = int'($signed(sin_o));
            held_c = int'($signed(cos_o));
            ce = 1'b0;
            for (int k = 0; k < 4; k++) begin
                phase = PW'(17 + 40 * k);
                step();
                check("R7", int'($signed(sin_o)), held_s);
                check("R7", int'($signed(cos_o)), held_c);
            end
            ce = 1'b1;
            repeat (ST + 1) step();
            // R8: mid-run reset clears both outputs
            tag_s = "R8"; tag_c = "R8";
            rst = 1'b1;
            step();
            check("R8", int'(sin_o), 0);
            check("R8", int'(cos_o), 0);
            step();
            rst = 1'b0;
            tag_s = "R1"; tag_c = "R2";
            phase = PW'(99);
            repeat (ST + 2) step();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule